// File: doc/BRIEF.md
# Banked Memory Attribute Indirection Registers

This block stores the attribute bytes that stage-1 translation entries point at through a 3-bit index. It holds two 32-bit registers of four 8-bit fields each. There is one secure copy and one non-secure copy of both registers, so four 32-bit words are stored in total.

A register port reads and writes one 32-bit register per strobe. Each access is qualified by the requester's privilege level, its security state, a bank selector that only the most privileged level uses, and an enable that says the long-descriptor table format is in force. A refused access raises an error flag in the same cycle. A refused write changes nothing, and a refused read returns zero. While the secure lock input is high, writes that target the secure copies are dropped without an error.

A separate combinational lookup port takes a translation entry's attribute index and the security state of the access. It returns the matching byte from the copy that belongs to that state.

Top module: `attr_indir_regs`

## Requirements
- R1: A synchronous active-high `rst` clears all four stored words to zero, so every lookup and every granted read returns zero afterwards.
- R2: Lookup index bit 2 picks the register (0 = register 0, 1 = register 1). Bits [1:0] pick field f, which lies in bits [8f+7:8f] of that register. Attribute k therefore sits in register k/4 at field k mod 4.
- R3: `lk_ns`=1 makes the lookup read the non-secure copy, and `lk_ns`=0 makes it read the secure copy.
- R4: Level encoding on `acc_lvl`: 0 = user, 1 = kernel, 2 = hypervisor, 3 = monitor. An access at level 0 is refused: `acc_err`=1, read data is zero, and a write leaves all stored words unchanged.
- R5: An access with `fmt_long`=0 is refused at every level, with the same effects as R4.
- R6: Routing of a granted access. At level 3, `acc_sel_ns` picks the copy (1 = non-secure, 0 = secure). Level 2 always reaches the non-secure copy. Level 1 reaches the non-secure copy when `acc_ns`=1 and the secure copy when `acc_ns`=0. `acc_reg` picks register 0 or 1.
- R7: While `sec_lock`=1, a write routed to a secure copy is dropped and raises no error. Reads of the secure copies still return their contents, and writes to the non-secure copies still take effect.
- R8: `acc_rdata` is combinational. During a granted strobe it shows the routed register, and it is zero when there is no strobe or the access is refused. `acc_err` is high only during a refused strobe.
- R9: An accepted write is stored on the clock edge that ends its strobe. Lookups show the new value from the next cycle on, and during the strobe they still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_lvl | input | 2 | Privilege level of the requester |
| acc_ns | input | 1 | Requester is in non-secure state (used at level 1) |
| acc_sel_ns | input | 1 | Bank selector used at level 3 |
| fmt_long | input | 1 | Long-descriptor format enable |
| acc_reg | input | 1 | Register select |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data |
| acc_err | output | 1 | Refused-access response |
| sec_lock | input | 1 | Freezes the secure copies against writes |
| lk_idx | input | 3 | Attribute index from a translation entry |
| lk_ns | input | 1 | Security state of the lookup |
| lk_attr | output | 8 | Selected attribute byte |

## Verification
The assertions assume that each strobe lasts exactly one cycle. They also assume that `acc_lvl`, the security inputs, `fmt_long` and `sec_lock` stay steady across the edge that ends a strobe, so that the stability and write-landing properties sample a settled request. The bench keeps to this by changing every input only just after a falling edge and lowering the strobe just after the rising edge. Lookups are driven independently of the access port, including in the middle of a strobe, so that the old-value-until-the-edge behaviour is exercised.

// File: rtl/attr_indir_pkg.sv
package attr_indir_pkg;
  localparam int ATTR_W = 8;
  localparam int FIELDS = 4;
  localparam int NREG   = 2;

  typedef enum logic [1:0] {
    LVL_USR = 2'd0,
    LVL_OS  = 2'd1,
    LVL_HYP = 2'd2,
    LVL_MON = 2'd3
  } lvl_e;

  // Copy reached by an access: 1 = non-secure, 0 = secure.
  function automatic logic route_ns(lvl_e lvl, logic req_ns, logic sel_ns);
    case (lvl)
      LVL_MON: return sel_ns;
      LVL_HYP: return 1'b1;
      default: return req_ns;
    endcase
  endfunction

  // Permission: the long format must be on, and level 0 is never allowed.
  function automatic logic lvl_allowed(lvl_e lvl, logic fmt_on);
    return fmt_on && (lvl != LVL_USR);
  endfunction
endpackage

// File: rtl/attr_access_gate.sv
module attr_access_gate
  import attr_indir_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic write,
  input  lvl_e lvl,
  input  logic req_ns,
  input  logic sel_ns,
  input  logic fmt_on,
  input  logic lock,
  output logic grant,
  output logic refuse,
  output logic to_ns,
  output logic wr_fire
);
  logic allowed;
  logic lock_drop;

  always_comb begin
    allowed   = lvl_allowed(lvl, fmt_on);
    to_ns     = route_ns(lvl, req_ns, sel_ns);
    grant     = valid && allowed;
    refuse    = valid && !allowed;
    lock_drop = grant && write && lock && !to_ns;
    wr_fire   = grant && write && !lock_drop;
  end

  p_user_refused_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && lvl == LVL_USR) |-> (refuse && !wr_fire));

  p_hyp_nonsecure_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && lvl == LVL_HYP) |-> to_ns);

  p_lock_no_error_r7: assert property (@(posedge clk) disable iff (rst)
    lock_drop |-> !refuse);
endmodule

// File: rtl/attr_store.sv
module attr_store #(
  parameter int NREG   = attr_indir_pkg::NREG,
  parameter int REG_W  = attr_indir_pkg::ATTR_W * attr_indir_pkg::FIELDS,
  localparam int RSEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_fire,
  input  logic                             wr_ns,
  input  logic [RSEL_W-1:0]                wr_reg,
  input  logic [REG_W-1:0]                 wdata,
  output logic [1:0][NREG-1:0][REG_W-1:0]  regs_q
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic hit;
      assign hit = wr_fire && (wr_ns == b[0]) && (wr_reg == r[RSEL_W-1:0]);
      always_ff @(posedge clk) begin
        if (rst)      regs_q[b][r] <= '0;
        else if (hit) regs_q[b][r] <= wdata;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (regs_q == '0));

  p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (regs_q[$past(wr_ns)][$past(wr_reg)] == $past(wdata)));
endmodule

// File: rtl/attr_select.sv
module attr_select #(
  parameter int ATTR_W = attr_indir_pkg::ATTR_W,
  parameter int FIELDS = attr_indir_pkg::FIELDS,
  parameter int NREG   = attr_indir_pkg::NREG,
  localparam int REG_W  = ATTR_W * FIELDS,
  localparam int FSEL_W = $clog2(FIELDS),
  localparam int IDX_W  = $clog2(FIELDS * NREG),
  localparam int RSEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [1:0][NREG-1:0][REG_W-1:0] regs,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            ns,
  output logic [ATTR_W-1:0]               attr
);
  logic [RSEL_W-1:0] reg_sel;
  logic [FSEL_W-1:0] fld_sel;
  logic [REG_W-1:0]  word;

  always_comb begin
    reg_sel = RSEL_W'(idx >> FSEL_W);
    fld_sel = idx[FSEL_W-1:0];
    word    = regs[ns][reg_sel];
    attr    = word[fld_sel*ATTR_W +: ATTR_W];
  end
endmodule

// File: rtl/attr_indir_regs.sv
module attr_indir_regs
  import attr_indir_pkg::*;
#(
  localparam int REG_W  = ATTR_W * FIELDS,
  localparam int IDX_W  = $clog2(FIELDS * NREG),
  localparam int RSEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [1:0]        acc_lvl,
  input  logic              acc_ns,
  input  logic              acc_sel_ns,
  input  logic              fmt_long,
  input  logic [RSEL_W-1:0] acc_reg,
  input  logic [REG_W-1:0]  acc_wdata,
  output logic [REG_W-1:0]  acc_rdata,
  output logic              acc_err,
  input  logic              sec_lock,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_ns,
  output logic [ATTR_W-1:0] lk_attr
);
  logic grant, refuse, to_ns, wr_fire;
  logic [1:0][NREG-1:0][REG_W-1:0] regs;

  attr_access_gate u_gate (
    .clk(clk), .rst(rst), .valid(acc_valid), .write(acc_write),
    .lvl(lvl_e'(acc_lvl)), .req_ns(acc_ns), .sel_ns(acc_sel_ns),
    .fmt_on(fmt_long), .lock(sec_lock), .grant(grant), .refuse(refuse),
    .to_ns(to_ns), .wr_fire(wr_fire)
  );

  attr_store #(.NREG(NREG), .REG_W(REG_W)) u_store (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_ns(to_ns),
    .wr_reg(acc_reg), .wdata(acc_wdata), .regs_q(regs)
  );

  attr_select #(.ATTR_W(ATTR_W), .FIELDS(FIELDS), .NREG(NREG)) u_sel (
    .regs(regs), .idx(lk_idx), .ns(lk_ns), .attr(lk_attr)
  );

  always_comb begin
    acc_err   = refuse;
    acc_rdata = grant ? regs[to_ns][acc_reg] : '0;
  end

  p_refused_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> (acc_rdata == '0));

  p_refused_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_err && !rst) |=> $stable(regs));

  p_fmt_refuse_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !fmt_long) |-> acc_err);

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sec_lock && !rst) |=> $stable(regs[0]));
endmodule

// File: tb/tb_attr_indir_regs.sv
module tb_attr_indir_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_write = 0, acc_ns = 0, acc_sel_ns = 0, fmt_long = 0;
  logic [1:0] acc_lvl = 0;
  logic [0:0] acc_reg = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] acc_rdata;
  logic acc_err;
  logic sec_lock = 0;
  logic [2:0] lk_idx = 0;
  logic lk_ns = 0;
  logic [7:0] lk_attr;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] m [2][2];

  always #5 clk = ~clk;

  attr_indir_regs dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_lvl(acc_lvl), .acc_ns(acc_ns), .acc_sel_ns(acc_sel_ns),
    .fmt_long(fmt_long), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err), .sec_lock(sec_lock),
    .lk_idx(lk_idx), .lk_ns(lk_ns), .lk_attr(lk_attr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d expected<=20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit tgt(input logic [1:0] el, input bit ns, input bit sel);
    if (el == 2'd3) return sel;
    if (el == 2'd2) return 1'b1;
    return ns;
  endfunction

  task automatic access(input bit w, input logic [1:0] el, input bit ns, input bit sel,
                        input bit fmt, input bit rs, input logic [31:0] d,
                        input bit exp_err, input string tag);
    bit t;
    t = tgt(el, ns, sel);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_lvl = el; acc_ns = ns; acc_sel_ns = sel;
    fmt_long = fmt; acc_reg = rs; acc_wdata = d;
    #1;
    chk({tag, " err"}, {31'd0, acc_err}, {31'd0, exp_err});
    if (!w) chk({tag, " rdata"}, acc_rdata, exp_err ? 32'd0 : m[t][rs]);
    @(posedge clk); #1;
    acc_valid = 0;
    if (w && !exp_err && !(sec_lock && !t)) m[t][rs] = d;
  endtask

  task automatic check_lookups(input string tag);
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 8; i++) begin
        lk_ns = b[0]; lk_idx = i[2:0]; #1;
        chk(tag, {24'd0, lk_attr}, {24'd0, m[b][i/4][(i%4)*8 +: 8]});
      end
    end
  endtask

  typedef struct packed {
    logic       w;
    logic [1:0] el;
    logic       ns;
    logic       sel;
    logic       fmt;
    logic       rs;
    logic [31:0] d;
    logic       err;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h11223344, 1'b0, 4'd6},  // R6 kernel ns
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h55667788, 1'b0, 4'd6},  // R6 kernel secure
    '{1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 32'h99AABBCC, 1'b0, 4'd6},  // R6 hyp always ns
    '{1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0BADF00D, 1'b0, 4'd6},  // R6 monitor sel 0
    '{1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 32'hC0FFEE12, 1'b0, 4'd6},  // R6 monitor sel 1
    '{1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 1'b1, 4'd4},  // R4 user write
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b1, 4'd5},  // R5 format off
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,        1'b0, 4'd8},  // R8 read ns r0
    '{1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,        1'b0, 4'd8},  // R8 read s r1
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,        1'b1, 4'd4},  // R4 user read
    '{1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0,        1'b1, 4'd5},  // R5 format off read
    '{1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0,        1'b0, 4'd6}   // R6 hyp read ns r1
  };

  initial begin
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 2; r++) m[b][r] = 32'd0;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1: reset state, lookups and a read
    check_lookups("R1 lookup after reset");
    access(0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0, "R1 read after reset");
    #1 chk("R8 idle rdata", acc_rdata, 32'd0);
    chk("R8 idle err", {31'd0, acc_err}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v].w, VEC[v].el, VEC[v].ns, VEC[v].sel, VEC[v].fmt, VEC[v].rs,
             VEC[v].d, VEC[v].err, $sformatf("R%0d vector %0d", VEC[v].req, v));
    end

    // R2, R3: every index in both copies
    check_lookups("R2 R3 lookup fields");

    // R9: old value during strobe, new value next cycle
    lk_ns = 1; lk_idx = 3'd5;
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_lvl = 2'd1; acc_ns = 1; fmt_long = 1;
    acc_reg = 1; acc_wdata = 32'hA1B2C3D4;
    #1 chk("R9 lookup old during strobe", {24'd0, lk_attr}, {24'd0, m[1][1][15:8]});
    @(posedge clk); #1 acc_valid = 0; m[1][1] = 32'hA1B2C3D4;
    chk("R9 lookup new after edge", {24'd0, lk_attr}, 32'h000000C3);

    // R7: lock freezes secure copies, no error, ns writes still work
    @(negedge clk) sec_lock = 1;
    access(1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'h12345678, 1'b0, "R7 locked secure write");
    access(1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h87654321, 1'b0, "R7 locked kernel secure write");
    access(0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0, "R7 locked secure read");
    access(1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 32'h5A5A5A5A, 1'b0, "R7 locked ns write");
    check_lookups("R7 lookup under lock");
    @(negedge clk) sec_lock = 0;
    access(1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'h13579BDF, 1'b0, "R7 unlocked secure write");
    access(0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0, "R7 unlocked secure read");
    chk("R7 model secure r0", m[0][0], 32'h13579BDF);

    // R1: reset in the middle of a run
    @(negedge clk) rst = 1;
    @(posedge clk); #1 rst = 0;
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 2; r++) m[b][r] = 32'd0;
    check_lookups("R1 lookup after second reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule